// File: doc/BRIEF.md
# Serial Memory Command Front-End

This block is the serial slave side of a byte-wide memory that sits behind a four-wire serial bus (select, clock, data in, data out) plus a suspend input. The bus pins are brought into the block's own clock domain through a short synchronizer, and bus clock edges are found there. Each transaction begins when select falls. The first eight bits form a command byte. Depending on the command, a 16-bit address and data bytes follow, or read data is streamed back.

The block holds the array as a plain register memory. Its write port is driven by the neighbouring page-write logic. Data bytes and status bytes received from the bus are not written here. They are handed on as a per-byte stream, and a commit pulse follows when select rises, but only if the framing was correct. The write-enable latch, the protection policy and the timing of the internal write cycle live in other blocks. This block receives a `busy` flag and the current status byte from them, and sends them single-cycle request pulses.

The serial output is delivered as a data bit plus an output-enable. When `so_oe` is low, the pad is meant to float.

Top module: `spi_mem_front`

## Requirements
- R1: Input bits are taken on rising bus-clock edges and output bits change on falling bus-clock edges (bus modes 0 and 3). Every field travels most significant bit first.
- R2: A command byte is legal when bits 7..4 are zero and bits 2..0 are neither 000 nor 111. Bit 3 is ignored. The codes in bits 2..0 are: 110 set-enable, 100 clear-enable, 101 status read, 001 status write, 011 array read, 010 array write. Set-enable and clear-enable produce a `wel_set` or `wel_clr` pulse when select rises, provided exactly 8 bits were clocked.
- R3: Array read and array write take a 16-bit address, high byte first. Only the low ADDR_W bits select a location and the rest are ignored.
- R4: After an illegal command byte, `so_oe` stays low for the rest of the transaction and the rising edge of select produces no pulse.
- R5: A status write or array write commits only if the transaction ends on a byte boundary with at least one data byte. Set-enable and clear-enable act only if the transaction ends after exactly 8 bits. Any other bit count discards the request.
- R6: Array read returns the byte at the start address, then the following addresses, for as long as clocks continue. After the highest location it wraps to location 0.
- R7: Status read returns `status_in` repeatedly, one full byte after another.
- R8: While `busy` is high when a command byte completes, only status read is acted on. Every other command is treated as ignored and gives no output and no pulse.
- R9: While suspend is in effect, bus clock and data-in edges are ignored and `so_oe` is low. When suspend is released, the transaction continues from the bit where it stopped.
- R10: A change on `hold_n` takes effect only while the bus clock is low. A change made while the clock is high is deferred until the clock falls.
- R11: While select is high, `so_oe` is low. A rising edge of select ends the transaction and clears the bit count, so the next transaction starts with a fresh command byte.
- R12: Each complete data byte of an array write gives a `wbyte_vld` pulse carrying the address (start address, then +1 per byte, modulo the array) and the byte. A committed array write pulses `commit_arr`. A committed status write pulses `commit_sr`, with the last data byte on `sr_data`.
- R13: After reset, `so_oe` is low and no request pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Bus select, active low |
| sck | input | 1 | Bus clock |
| si | input | 1 | Bus data in |
| hold_n | input | 1 | Suspend, active low |
| busy | input | 1 | An internal write cycle is in progress |
| status_in | input | 8 | Current status byte returned by status read |
| mem_we | input | 1 | Array write strobe from the page-write logic |
| mem_waddr | input | ADDR_W | Array write address |
| mem_wdata | input | 8 | Array write data |
| so | output | 1 | Bus data out (valid while so_oe is high) |
| so_oe | output | 1 | Output enable for the data-out pad |
| wel_set | output | 1 | Pulse: set the write-enable latch |
| wel_clr | output | 1 | Pulse: clear the write-enable latch |
| wbyte_vld | output | 1 | Pulse: a data byte of an array write was received |
| wbyte_addr | output | ADDR_W | Array address of that byte |
| wbyte_data | output | 8 | Value of that byte |
| commit_arr | output | 1 | Pulse: the array write was correctly framed |
| commit_sr | output | 1 | Pulse: the status write was correctly framed |
| sr_data | output | 8 | Last status byte received |

## Verification
The bench builds the block with ADDR_W = 4, a 16-byte array, and SYNC_STAGES = 2. With only 16 locations, a sequential read crosses the top of the array after two bytes, so the wrap to location 0 is easy to reach. A 16-bit address with bits 15..4 set checks that the ignored address bits really are ignored. The bus clock runs at sixteen block clocks per period. This leaves room to insert suspend in both clock phases and to truncate frames at arbitrary bit counts.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [2:0] CMD_WRSR  = 3'b001;
  localparam logic [2:0] CMD_WRITE = 3'b010;
  localparam logic [2:0] CMD_READ  = 3'b011;
  localparam logic [2:0] CMD_WRDI  = 3'b100;
  localparam logic [2:0] CMD_RDSR  = 3'b101;
  localparam logic [2:0] CMD_WREN  = 3'b110;

  typedef enum logic [2:0] {
    PH_OPC,   // collecting the command byte
    PH_ADH,   // address high byte
    PH_ADL,   // address low byte
    PH_DAT,   // incoming data bytes
    PH_OUT,   // streaming read data
    PH_END,   // single-byte command complete, no more bits allowed
    PH_IGN    // rest of the transaction ignored
  } phase_t;

  function automatic logic op_legal(input logic [7:0] op);
    return (op[7:4] == 4'h0) && (op[2:0] != 3'b000) && (op[2:0] != 3'b111);
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[0] <= RST_VAL;
        else        st[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_op_decode.sv
module spi_op_decode
  import spi_mem_pkg::*;
(
  input  logic [7:0] op,
  input  logic       busy,
  output logic       accept,
  output logic [2:0] cmd
);
  assign cmd    = op[2:0];
  assign accept = op_legal(op) && (!busy || cmd == CMD_RDSR);
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (we) mem[waddr] <= wdata;

  assign rdata = mem[raddr];
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  input  logic              busy,
  input  logic [7:0]        status_in,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_waddr,
  input  logic [7:0]        mem_wdata,
  output logic              so,
  output logic              so_oe,
  output logic              wel_set,
  output logic              wel_clr,
  output logic              wbyte_vld,
  output logic [ADDR_W-1:0] wbyte_addr,
  output logic [7:0]        wbyte_data,
  output logic              commit_arr,
  output logic              commit_sr,
  output logic [7:0]        sr_data
);

  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // synchronized pins: select idles high, suspend idles released
  logic [3:0] sync_q;
  logic cs_s, sck_s, si_s, hold_s;
  spi_in_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si, hold_n}), .q(sync_q)
  );
  assign {cs_s, sck_s, si_s, hold_s} = sync_q;

  logic sck_d, cs_d, hold_eff;
  logic [2:0] bitcnt;
  logic [6:0] shin;
  phase_t phase;
  logic [2:0] cmd;
  logic [7:0] addr_hi, tx;
  logic [ADDR_W-1:0] ptr;
  logic so_q, oe_q, got_data;

  // named events
  wire sck_rise = sck_s & ~sck_d & ~cs_s & ~hold_eff;
  wire sck_fall = ~sck_s & sck_d & ~cs_s & ~hold_eff;
  wire cs_rise  = cs_s & ~cs_d;
  wire [7:0] rx_byte = {shin, si_s};
  wire byte_done = sck_rise && (bitcnt == 3'd7);
  wire opc_done  = byte_done && (phase == PH_OPC);
  wire write_ok  = (phase == PH_DAT) && (bitcnt == 3'd0) && got_data;
  wire latch_ok  = (phase == PH_END) && (bitcnt == 3'd0);

  logic dec_ok;
  logic [2:0] dec_cmd;
  spi_op_decode u_dec (.op(rx_byte), .busy(busy), .accept(dec_ok), .cmd(dec_cmd));

  logic [ADDR_W-1:0] start_addr, rd_addr;
  logic [7:0] mem_rdata;
  assign start_addr = ADDR_W'({addr_hi, rx_byte});
  assign rd_addr    = (phase == PH_ADL) ? start_addr : ptr;

  spi_mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0; cs_d <= 1'b1; hold_eff <= 1'b0;
      bitcnt <= '0; shin <= '0; phase <= PH_OPC; cmd <= '0;
      addr_hi <= '0; tx <= '0; ptr <= '0; so_q <= 1'b0; oe_q <= 1'b0;
      got_data <= 1'b0; wel_set <= 1'b0; wel_clr <= 1'b0;
      wbyte_vld <= 1'b0; wbyte_addr <= '0; wbyte_data <= '0;
      commit_arr <= 1'b0; commit_sr <= 1'b0; sr_data <= '0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
      wel_set <= 1'b0; wel_clr <= 1'b0; wbyte_vld <= 1'b0;
      commit_arr <= 1'b0; commit_sr <= 1'b0;
      if (!sck_s) hold_eff <= ~hold_s;
      oe_q <= ~cs_s && (phase == PH_OUT) && ~hold_eff;
      if (cs_s) begin
        if (cs_rise) begin
          commit_arr <= write_ok && (cmd == CMD_WRITE);
          commit_sr  <= write_ok && (cmd == CMD_WRSR);
          wel_set    <= latch_ok && (cmd == CMD_WREN);
          wel_clr    <= latch_ok && (cmd == CMD_WRDI);
        end
        bitcnt   <= '0;
        phase    <= PH_OPC;
        got_data <= 1'b0;
      end else if (sck_rise) begin
        shin   <= rx_byte[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (phase == PH_END) phase <= PH_IGN;
        if (bitcnt == 3'd7) begin
          case (phase)
            PH_OPC: begin
              if (!dec_ok) phase <= PH_IGN;
              else begin
                cmd <= dec_cmd;
                case (dec_cmd)
                  CMD_RDSR: begin phase <= PH_OUT; tx <= status_in; end
                  CMD_READ, CMD_WRITE: phase <= PH_ADH;
                  CMD_WRSR: phase <= PH_DAT;
                  default:  phase <= PH_END;
                endcase
              end
            end
            PH_ADH: begin addr_hi <= rx_byte; phase <= PH_ADL; end
            PH_ADL: begin
              if (cmd == CMD_READ) begin
                tx <= mem_rdata; ptr <= addr_next(start_addr); phase <= PH_OUT;
              end else begin
                ptr <= start_addr; phase <= PH_DAT;
              end
            end
            PH_DAT: begin
              got_data <= 1'b1;
              if (cmd == CMD_WRSR) sr_data <= rx_byte;
              else begin
                wbyte_vld <= 1'b1; wbyte_addr <= ptr; wbyte_data <= rx_byte;
                ptr <= addr_next(ptr);
              end
            end
            PH_OUT: begin
              if (cmd == CMD_RDSR) tx <= status_in;
              else begin tx <= mem_rdata; ptr <= addr_next(ptr); end
            end
            default: ;
          endcase
        end
      end else if (sck_fall && phase == PH_OUT) begin
        so_q <= tx[7];
        tx   <= {tx[6:0], 1'b0};
      end
    end
  end

  assign so    = oe_q ? so_q : 1'b0;
  assign so_oe = oe_q;

  AST_CS_QUIETS_SO: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !so_oe); // R11
  AST_IGN_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGN) |=> !(wel_set || wel_clr || commit_arr || commit_sr)); // R4
  AST_BUSY_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_done && busy && rx_byte[2:0] != CMD_RDSR) |=> (phase == PH_IGN)); // R8
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wel_set, wel_clr, commit_arr, commit_sr})); // R5
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_eff && !cs_s) |=> ($stable(bitcnt) && $stable(tx))); // R9
  AST_HOLD_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sck_s |=> $stable(hold_eff)); // R10
  AST_WBYTE_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wbyte_vld |-> ($past(phase) == PH_DAT && $past(cmd) == CMD_WRITE)); // R12

endmodule

// File: tb/spi_mem_front_bench.sv
module spi_mem_front_bench;
  localparam int AW = 4;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic mem_we = 1'b0;
  logic [AW-1:0] mem_waddr = '0;
  logic [7:0] mem_wdata = '0;
  logic so, so_oe, wel_set, wel_clr, wbyte_vld, commit_arr, commit_sr;
  logic [AW-1:0] wbyte_addr;
  logic [7:0] wbyte_data, sr_data;

  always #10 clk = ~clk;

  spi_mem_front #(.ADDR_W(AW), .SYNC_STAGES(2)) u_spi_mem_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .busy(busy), .status_in(status_in), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .so(so), .so_oe(so_oe), .wel_set(wel_set),
    .wel_clr(wel_clr), .wbyte_vld(wbyte_vld), .wbyte_addr(wbyte_addr),
    .wbyte_data(wbyte_data), .commit_arr(commit_arr), .commit_sr(commit_sr),
    .sr_data(sr_data)
  );

  int n_tests = 0, n_fail = 0;
  int n_set = 0, n_clr = 0, n_arr = 0, n_sr = 0, n_wb = 0;
  logic [AW-1:0] wb_a [8];
  logic [7:0] wb_d [8];
  bit oe_seen = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (wel_set) n_set++;
    if (wel_clr) n_clr++;
    if (commit_arr) n_arr++;
    if (commit_sr) n_sr++;
    if (so_oe) oe_seen = 1;
    if (wbyte_vld) begin
      if (n_wb < 8) begin wb_a[n_wb] = wbyte_addr; wb_d[n_wb] = wbyte_data; end
      n_wb++;
    end
  end

  function automatic logic [7:0] exp_mem(input int i);
    return 8'h3C ^ 8'(i * 29);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts();
    n_set = 0; n_clr = 0; n_arr = 0; n_sr = 0; n_wb = 0; oe_seen = 0;
  endtask

  task automatic xbit(input logic b, output logic r);
    si = b;
    tick(HALF);
    r = so;
    sck = 1'b1;
    tick(HALF);
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      logic t;
      xbit(b[i], t);
      r[i] = t;
    end
  endtask

  task automatic cs_start();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic cs_end();
    tick(HALF);
    cs_n = 1'b1;
    tick(12);
  endtask

  task automatic t_reset();
    clear_counts();
    tick(10);
    check(so_oe == 1'b0, "R13 so_oe after reset", so_oe, 0);
    check(n_set + n_clr + n_arr + n_sr + n_wb == 0, "R13 no pulses after reset",
          n_set + n_clr + n_arr + n_sr + n_wb, 0);
  endtask

  task automatic t_read_wrap();
    logic [7:0] r;
    clear_counts();
    cs_start();
    xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h0E, r);
    for (int k = 0; k < 4; k++) begin
      xbyte(8'h00, r);
      check(r == exp_mem((14 + k) % 16), "R6 R1 sequential read with wrap", r, exp_mem((14 + k) % 16));
    end
    check(so_oe == 1'b1, "R1 output enabled while reading", so_oe, 1);
    tick(HALF);
    cs_n = 1'b1;
    tick(6);
    check(so_oe == 1'b0, "R11 output off after select rises", so_oe, 0);
    tick(6);
  endtask

  task automatic t_read_highbits();
    logic [7:0] r;
    cs_start();
    xbyte(8'h0B, r); xbyte(8'hFF, r); xbyte(8'hF5, r);
    xbyte(8'h00, r);
    check(r == exp_mem(5), "R3 R2 high address bits and opcode bit 3 ignored", r, exp_mem(5));
    cs_end();
  endtask

  task automatic t_status_read();
    logic [7:0] r;
    status_in = 8'h8D;
    cs_start();
    xbyte(8'h05, r);
    for (int k = 0; k < 3; k++) begin
      xbyte(8'h00, r);
      check(r == 8'h8D, "R7 status byte repeats", r, 8'h8D);
    end
    cs_end();
  endtask

  task automatic t_latch_cmds();
    logic [7:0] r;
    clear_counts();
    cs_start(); xbyte(8'h06, r); cs_end();
    check(n_set == 1, "R2 set-enable pulse", n_set, 1);
    cs_start(); xbyte(8'h0E, r); cs_end();
    check(n_set == 2, "R2 set-enable with bit 3 set", n_set, 2);
    cs_start(); xbyte(8'h04, r); cs_end();
    check(n_clr == 1 && n_set == 2, "R2 clear-enable pulse", n_clr, 1);
  endtask

  task automatic t_invalid();
    logic [7:0] r;
    logic [7:0] ops [3] = '{8'h07, 8'h16, 8'h00};
    foreach (ops[k]) begin
      clear_counts();
      cs_start();
      xbyte(ops[k], r); xbyte(8'h00, r); xbyte(8'h00, r);
      cs_end();
      check(!oe_seen, "R4 illegal opcode keeps output off", oe_seen, 0);
      check(n_set + n_clr + n_arr + n_sr + n_wb == 0, "R4 illegal opcode gives no pulse",
            n_set + n_clr + n_arr + n_sr + n_wb, 0);
    end
  endtask

  task automatic t_write_array();
    logic [7:0] r;
    clear_counts();
    cs_start();
    xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h0E, r);
    xbyte(8'h11, r); xbyte(8'h22, r); xbyte(8'h33, r);
    cs_end();
    check(n_wb == 3, "R12 byte stream count", n_wb, 3);
    check(wb_a[0] == 4'hE && wb_d[0] == 8'h11, "R12 first byte", {wb_a[0], wb_d[0]}, 12'hE11);
    check(wb_a[1] == 4'hF && wb_d[1] == 8'h22, "R12 second byte", {wb_a[1], wb_d[1]}, 12'hF22);
    check(wb_a[2] == 4'h0 && wb_d[2] == 8'h33, "R12 third byte wraps address", {wb_a[2], wb_d[2]}, 12'h033);
    check(n_arr == 1 && n_sr == 0, "R12 array commit", n_arr, 1);
  endtask

  task automatic t_write_status();
    logic [7:0] r;
    clear_counts();
    cs_start(); xbyte(8'h01, r); xbyte(8'h9C, r); cs_end();
    check(n_sr == 1 && n_arr == 0, "R12 status commit", n_sr, 1);
    check(sr_data == 8'h9C, "R12 status data", sr_data, 8'h9C);
  endtask

  task automatic t_bad_counts();
    logic [7:0] r;
    logic t;
    clear_counts();
    cs_start(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h03, r); cs_end();
    check(n_arr == 0, "R5 write without data discarded", n_arr, 0);
    cs_start(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h03, r); xbyte(8'h55, r);
    for (int i = 0; i < 3; i++) xbit(1'b1, t);
    cs_end();
    check(n_arr == 0, "R5 write with partial byte discarded", n_arr, 0);
    cs_start(); xbyte(8'h01, r); cs_end();
    check(n_sr == 0, "R5 status write without data discarded", n_sr, 0);
    cs_start(); xbyte(8'h06, r); xbit(1'b0, t); cs_end();
    check(n_set == 0, "R5 set-enable with extra bit discarded", n_set, 0);
    cs_start(); xbyte(8'h06, r); xbyte(8'h00, r); cs_end();
    check(n_set == 0, "R5 set-enable with extra byte discarded", n_set, 0);
  endtask

  task automatic t_busy();
    logic [7:0] r;
    busy = 1'b1;
    status_in = 8'hF1;
    clear_counts();
    cs_start(); xbyte(8'h06, r); cs_end();
    check(n_set == 0, "R8 set-enable ignored while busy", n_set, 0);
    cs_start(); xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h01, r); xbyte(8'h00, r); cs_end();
    check(!oe_seen, "R8 array read ignored while busy", oe_seen, 0);
    cs_start(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h01, r); xbyte(8'hAA, r); cs_end();
    check(n_arr == 0 && n_wb == 0, "R8 array write ignored while busy", n_arr + n_wb, 0);
    cs_start(); xbyte(8'h05, r); xbyte(8'h00, r); cs_end();
    check(r == 8'hF1, "R8 status read served while busy", r, 8'hF1);
    busy = 1'b0;
  endtask

  task automatic t_hold();
    logic [7:0] r, d;
    logic t;
    cs_start();
    xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h02, r);
    for (int i = 7; i >= 5; i--) begin xbit(1'b0, t); d[i] = t; end
    tick(2);
    hold_n = 1'b0;
    tick(HALF);
    check(so_oe == 1'b0, "R9 output off during suspend", so_oe, 0);
    for (int k = 0; k < 4; k++) begin xbit(k[0], t); end
    tick(2);
    check(so_oe == 1'b0, "R9 output stays off while clocks ignored", so_oe, 0);
    hold_n = 1'b1;
    tick(HALF);
    for (int i = 4; i >= 0; i--) begin xbit(1'b0, t); d[i] = t; end
    check(d == exp_mem(2), "R9 read resumes after suspend", d, exp_mem(2));
    xbyte(8'h00, r);
    check(r == exp_mem(3), "R9 next byte after suspend", r, exp_mem(3));
    cs_end();
  endtask

  task automatic t_hold_sck_high();
    logic [7:0] d;
    logic t;
    status_in = 8'hB6;
    cs_start();
    xbyte(8'h05, d);
    for (int i = 7; i >= 0; i--) begin
      if (i == 4) begin
        si = 1'b0;
        tick(HALF);
        d[i] = so;
        sck = 1'b1;
        tick(2);
        hold_n = 1'b0;
        tick(6);
        check(so_oe == 1'b1, "R10 suspend deferred while clock high", so_oe, 1);
        sck = 1'b0;
        tick(HALF);
        check(so_oe == 1'b0, "R10 suspend applies once clock low", so_oe, 0);
        hold_n = 1'b1;
        tick(HALF);
      end else begin
        xbit(1'b0, t);
        d[i] = t;
      end
    end
    check(d == 8'hB6, "R10 status byte intact across suspend", d, 8'hB6);
    cs_end();
  endtask

  task automatic t_cs_resets();
    logic [7:0] r;
    logic t;
    clear_counts();
    cs_start();
    for (int i = 0; i < 5; i++) xbit(1'b0, t);
    cs_end();
    cs_start(); xbyte(8'h06, r); cs_end();
    check(n_set == 1, "R11 new transaction starts at command byte", n_set, 1);
    check(so_oe == 1'b0, "R11 output off while select high", so_oe, 0);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(3);
    t_reset();
    for (int i = 0; i < 16; i++) begin
      mem_we = 1'b1; mem_waddr = AW'(i); mem_wdata = exp_mem(i);
      tick(1);
    end
    mem_we = 1'b0;
    tick(4);
    t_read_wrap();
    t_read_highbits();
    t_status_read();
    t_latch_cmds();
    t_invalid();
    t_write_array();
    t_write_status();
    t_bad_counts();
    t_busy();
    t_hold();
    t_hold_sck_high();
    t_cs_resets();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule